// File: doc/BRIEF.md
# Packed Rounding Average Unit

This block takes two packed operands of unsigned lanes and returns, lane by lane, their average rounded upward. Each result lane is the sum of the two source lanes plus one, halved. A single select input sets the lane width for the operation to either 8 or 16 bits. All lanes are handled in parallel in one operation.

The datapath is one shared 8-bit segmented adder. Each byte segment forms a 9-bit sum, so a lane never loses its carry out. In 8-bit mode every segment starts its own lane. In 16-bit mode carries move only from the low byte of a word into its high byte. Carries never pass across a lane edge in either mode.

The operand width is a parameter. It is 64 bits by default, and 128 bits is also legal. A strobe qualifies the operands, and the packed result is registered with a valid flag one cycle later.

Top module: `rnd_avg_simd`

## Requirements
- R1: After reset, `res_valid_o` is 0 and `res_data_o` is all zeros.
- R2: With `lane_sel_i` = 0 (8-bit lanes), each byte k of the result equals (A.byte k + B.byte k + 1) >> 1. The sum is computed at 9 bits.
- R3: With `lane_sel_i` = 1 (16-bit lanes), each 16-bit lane k of the result equals (A.lane k + B.lane k + 1) >> 1. The sum is computed at 17 bits.
- R4: The carry from one lane never changes a neighbouring lane. An all-ones lane pair next to an all-zeros lane pair leaves the zero lane at 0x00 (or 0x0000).
- R5: The carry out of a lane is kept as the result's top bit. 0xFF averaged with 0xFF gives 0xFF, and 0xFFFF averaged with 0xFFFF gives 0xFFFF.
- R6: Halves round upward. 0x00 averaged with 0x01 gives 0x01 in both lane modes.
- R7: `res_valid_o` is high in exactly the cycle after a cycle in which `in_valid_i` was high. The result of those operands shows on `res_data_o` at the same time.
- R8: While `in_valid_i` is low, operand and mode changes are ignored and `res_data_o` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operands and mode are valid this cycle |
| lane_sel_i | input | 1 | Lane width: 0 = 8-bit, 1 = 16-bit |
| opa_i | input | DATA_W | First packed operand |
| opb_i | input | DATA_W | Second packed operand |
| res_valid_o | output | 1 | Result valid, one cycle after `in_valid_i` |
| res_data_o | output | DATA_W | Packed rounded averages |

## Verification
A wrong segment carry does not stay inside the unit. It shows in the very next cycle as a result lane that is off by 0x80 or 0x8000 in its top bit, or off by one in the low bit of the lane above it. The exhaustive 8-bit sweep and the 16-bit pattern sweep therefore catch it within one operation. A register that captures without the strobe shows up as a changed `res_data_o` while `res_valid_o` stays low.

// File: rtl/ravg_pkg.sv
package ravg_pkg;
   localparam int unsigned SEG_W = 8;

   typedef enum logic {
      LANE_B8  = 1'b0,
      LANE_W16 = 1'b1
   } lane_mode_e;
endpackage

// File: rtl/ravg_lane_map.sv
// Converts the lane mode into per-segment control: where a lane starts
// (carry-in forced to the +1 rounding term) and where a lane ends
// (segment carry-out becomes the lane's result MSB).
module ravg_lane_map
   import ravg_pkg::*;
#(
   parameter int unsigned NSEG = 8
) (
   input  lane_mode_e       mode_i,
   output logic [NSEG-1:0]  seg_start_o,
   output logic [NSEG-1:0]  seg_top_o
);
   for (genvar g = 0; g < NSEG; g++) begin : g_map
      if ((g % 2) == 0) begin : g_even
         assign seg_start_o[g] = 1'b1;
         assign seg_top_o[g]   = (mode_i == LANE_B8);
      end else begin : g_odd
         assign seg_start_o[g] = (mode_i == LANE_B8);
         assign seg_top_o[g]   = 1'b1;
      end
   end

   // Every lane has exactly one start and one end segment.
   always_comb begin
      if (!$isunknown(mode_i)) begin
         a_start_top_count_r4: assert ($countones(seg_start_o) == $countones(seg_top_o))
            else $error("lane start/end segment counts differ");
      end
   end
endmodule

// File: rtl/ravg_seg_adder.sv
// Shared adder cut into byte segments. Each segment forms a 9-bit sum so the
// lane carry-out is retained; the halving shift pulls each segment's MSB either
// from its own carry (lane top) or from bit 0 of the segment above.
module ravg_seg_adder
   import ravg_pkg::*;
#(
   parameter int unsigned NSEG = 8,
   localparam int unsigned W   = NSEG * SEG_W
) (
   input  logic [W-1:0]    a_i,
   input  logic [W-1:0]    b_i,
   input  logic [NSEG-1:0] seg_start_i,
   input  logic [NSEG-1:0] seg_top_i,
   output logic [W-1:0]    avg_o
);
   for (genvar g = 0; g < NSEG; g++) begin : g_seg
      logic             c_in;
      logic [SEG_W:0]   sum;
      logic             c_out;

      if (g == 0) begin : g_first
         assign c_in = 1'b1;
      end else begin : g_rest
         assign c_in = seg_start_i[g] ? 1'b1 : g_seg[g-1].c_out;
      end

      assign sum   = {1'b0, a_i[g*SEG_W +: SEG_W]} + {1'b0, b_i[g*SEG_W +: SEG_W]}
                   + {{SEG_W{1'b0}}, c_in};
      assign c_out = sum[SEG_W];

      assign avg_o[g*SEG_W +: SEG_W-1] = sum[SEG_W-1:1];
      if (g == NSEG-1) begin : g_last
         assign avg_o[g*SEG_W + SEG_W-1] = c_out;
      end else begin : g_mid
         assign avg_o[g*SEG_W + SEG_W-1] = seg_top_i[g] ? c_out : g_seg[g+1].sum[0];
      end
   end
endmodule

// File: rtl/rnd_avg_simd.sv
module rnd_avg_simd
   import ravg_pkg::*;
#(
   parameter int unsigned DATA_W = 64,
   localparam int unsigned NSEG  = DATA_W / SEG_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              in_valid_i,
   input  logic              lane_sel_i,
   input  logic [DATA_W-1:0] opa_i,
   input  logic [DATA_W-1:0] opb_i,
   output logic              res_valid_o,
   output logic [DATA_W-1:0] res_data_o
);
   if (DATA_W != 64 && DATA_W != 128) begin : g_bad_width
      $error("rnd_avg_simd: DATA_W must be 64 or 128");
   end

   lane_mode_e        mode;
   logic [NSEG-1:0]   seg_start;
   logic [NSEG-1:0]   seg_top;
   logic [DATA_W-1:0] avg_comb;

   assign mode = lane_mode_e'(lane_sel_i);

   ravg_lane_map #(.NSEG(NSEG)) map_i (
      .mode_i      (mode),
      .seg_start_o (seg_start),
      .seg_top_o   (seg_top)
   );

   ravg_seg_adder #(.NSEG(NSEG)) add_i (
      .a_i         (opa_i),
      .b_i         (opb_i),
      .seg_start_i (seg_start),
      .seg_top_i   (seg_top),
      .avg_o       (avg_comb)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         res_valid_o <= 1'b0;
         res_data_o  <= '0;
      end else begin
         res_valid_o <= in_valid_i;
         if (in_valid_i) begin
            res_data_o <= avg_comb;
         end
      end
   end

   // R7: valid follows the strobe by exactly one cycle.
   p_valid_lat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      res_valid_o == $past(in_valid_i));

   // R8: no strobe, no change of the result.
   p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !in_valid_i |=> $stable(res_data_o));

   // R2: a byte average lies between its two operands.
   p_bounds_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i && !lane_sel_i) |=>
         (res_data_o[7:0] >= (($past(opa_i[7:0]) < $past(opb_i[7:0])) ? $past(opa_i[7:0]) : $past(opb_i[7:0])))
      && (res_data_o[7:0] <= (($past(opa_i[7:0]) > $past(opb_i[7:0])) ? $past(opa_i[7:0]) : $past(opb_i[7:0]))));

   // R3: equal operands average to themselves in word mode (carry kept).
   p_equal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i && lane_sel_i && (opa_i == opb_i)) |=> (res_data_o == $past(opa_i)));
endmodule

// File: tb/rnd_avg_simd_tb_top.sv
`timescale 1ns/1ps
module rnd_avg_simd_tb_top;
   localparam int unsigned DW = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          lane_sel = 1'b0;
   logic [DW-1:0] opa = '0;
   logic [DW-1:0] opb = '0;
   logic          res_valid;
   logic [DW-1:0] res_data;

   int unsigned n_chk = 0;
   int unsigned n_fail = 0;
   logic [31:0] rng = 32'h1234_5678;

   always #2.5 clk = ~clk;  // 200 MHz

   rnd_avg_simd #(.DATA_W(DW)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .lane_sel_i(lane_sel),
      .opa_i(opa), .opb_i(opb), .res_valid_o(res_valid), .res_data_o(res_data)
   );

   function automatic logic [DW-1:0] model(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                           input logic word);
      logic [DW-1:0] r = '0;
      if (!word) begin
         for (int i = 0; i < DW/8; i++) begin
            logic [8:0] s = {1'b0, a[i*8 +: 8]} + {1'b0, b[i*8 +: 8]} + 9'd1;
            r[i*8 +: 8] = s[8:1];
         end
      end else begin
         for (int i = 0; i < DW/16; i++) begin
            logic [16:0] s = {1'b0, a[i*16 +: 16]} + {1'b0, b[i*16 +: 16]} + 17'd1;
            r[i*16 +: 16] = s[16:1];
         end
      end
      return r;
   endfunction

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   // One strobed operation; result checked just after the capturing edge.
   task automatic op(input string req, input logic word, input logic [DW-1:0] a,
                     input logic [DW-1:0] b);
      @(negedge clk);
      in_valid = 1'b1; lane_sel = word; opa = a; opb = b;
      @(posedge clk); #1;
      check(req, {{(DW-1){1'b0}}, res_valid}, {{(DW-1){1'b0}}, 1'b1});
      check(req, res_data, model(a, b, word));
   endtask

   function automatic logic [31:0] xs(input logic [31:0] x);
      logic [31:0] y = x;
      y ^= y << 13; y ^= y >> 17; y ^= y << 5;
      return y;
   endfunction

   initial begin
      #200000000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [DW-1:0] held;
      repeat (3) @(posedge clk);
      #1;
      check("R1", {{(DW-1){1'b0}}, res_valid}, '0);   // R1
      check("R1", res_data, '0);
      @(negedge clk); rst_n = 1'b1;

      // R6: round up
      op("R6", 1'b0, 64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101);
      op("R6", 1'b1, 64'h0000_0000_0000_0000, 64'h0001_0001_0001_0001);
      // R5: carry kept
      op("R5", 1'b0, {DW{1'b1}}, {DW{1'b1}});
      op("R5", 1'b1, {DW{1'b1}}, {DW{1'b1}});
      // R4: no carry between lanes
      op("R4", 1'b0, 64'hFF00_FF00_FF00_FF00, 64'hFF00_FF00_FF00_FF00);
      op("R4", 1'b0, 64'h00FF_00FF_00FF_00FF, 64'h00FF_00FF_00FF_00FF);
      op("R4", 1'b1, 64'hFFFF_0000_FFFF_0000, 64'hFFFF_0000_FFFF_0000);
      op("R4", 1'b1, 64'h0000_FFFF_0000_FFFF, 64'h0000_FFFF_0000_FFFF);
      op("R3", 1'b1, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001);

      // R2: exhaustive byte pairs, distinct per lane
      for (int a = 0; a < 256; a++) begin
         for (int b = 0; b < 256; b++) begin
            logic [DW-1:0] va, vb;
            for (int k = 0; k < DW/8; k++) begin
               va[k*8 +: 8] = 8'(a) ^ 8'(k * 37);
               vb[k*8 +: 8] = 8'(b) + 8'(k * 11);
            end
            op("R2", 1'b0, va, vb);
         end
      end

      // R3: word lanes, pseudo-random plus edges
      for (int n = 0; n < 8000; n++) begin
         logic [DW-1:0] va, vb;
         rng = xs(rng); va[31:0] = rng; rng = xs(rng); va[63:32] = rng;
         rng = xs(rng); vb[31:0] = rng; rng = xs(rng); vb[63:32] = rng;
         op("R3", 1'b1, va, vb);
      end

      // R7: valid timing around a gap
      @(negedge clk); in_valid = 1'b0;
      @(posedge clk); #1;
      check("R7", {{(DW-1){1'b0}}, res_valid}, '0);
      op("R7", 1'b0, 64'h1020_3040_5060_7080, 64'h0102_0304_0506_0708);
      @(negedge clk); in_valid = 1'b0;
      @(posedge clk); #1;
      check("R7", {{(DW-1){1'b0}}, res_valid}, '0);

      // R8: changes without strobe are ignored
      held = res_data;
      for (int n = 0; n < 4; n++) begin
         @(negedge clk);
         lane_sel = ~lane_sel; opa = ~opa ^ 64'(n); opb = opb + 64'h0F0F;
      end
      @(posedge clk); #1;
      check("R8", res_data, held);
      check("R8", {{(DW-1){1'b0}}, res_valid}, '0);

      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule